// File: doc/BRIEF.md
# Translation Table Management Register Port

This block is the register window through which software maintains an address translation table. A 32-bit single-cycle register bus reaches six registers: an entry selector, the tag word and data word of the selected entry, a process-ID register, a zone register and a search register. Table entries are reached only indirectly. Software first loads the selector, then reads or writes the tag or data word of that entry.

Writing the tag word also stamps the entry with the current process ID. Reading the tag word loads the process-ID register with the ID stored in that entry. Writing an address to the search register runs a parallel lookup over the whole table and writes the result back into the selector, with a miss flag. The lookup matches on valid bit, page size, page number and process ID.

Every change that can make downstream cached translations stale produces a one-cycle flush indication. This happens when an entry's tag is rewritten, when the process ID changes, and when the zone register changes. The indication is either a whole-cache flush or a bitmask naming the affected entries.

Top module: `tlb_mgmt_regif`

## Requirements
- R1: After reset every register, tag word, data word and stored ID reads as zero. Every entry is therefore invalid, and a search misses.
- R2: The register select codes are: 0 data word, 1 tag word, 2 process ID, 3 zone, 4 selector, 5 search. Bit 0 of the code picks data versus tag. Reads of 5, 6 and 7 return zero and writes to 6 and 7 do nothing. Read data appears on `regRdData` in the cycle after the read edge and holds until the next read. A cycle with both enables raised is a write.
- R3: The tag and data words accessed are those of the entry numbered by bits 7:0 of the selector register.
- R4: A tag write stores bits 7:0 of the process-ID register as the entry's ID. A tag read loads the process-ID register with that stored ID, zero-extended.
- R5: A search takes the written value with bits 9:0 cleared. An entry matches when all of the following hold: tag bit 6 (valid) is set; the address and the tag agree above the page size, where the size is 1 KiB times 4 to the power of tag bits 9:7; and the entry's ID is zero or equals process-ID bits 7:0. On a hit the selector becomes the entry number with bit 31 clear.
- R6: On a search miss the selector becomes 0x8000_0000. This includes an entry whose address matches but whose nonzero ID differs from the process ID.
- R7: A zone write whose value differs from the held value raises `flushValid` and `flushAll` for exactly the next cycle. A zone write with an equal value, and any read, raises no flush.
- R8: A process-ID write with a new value flushes, through `flushEntries`, every valid entry whose nonzero ID equals bits 7:0 of the outgoing process ID. An equal value flushes nothing.
- R9: A tag write flushes the addressed entry alone (one-hot `flushEntries`) when its previous tag was valid, and flushes nothing otherwise.
- R10: When several entries match a search, the lowest-numbered entry wins.
- R11: A selector value of table size or more makes data and tag writes do nothing and raise no flush. Tag and data reads then return zero and leave the process ID unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regSel | input | 3 | Register select code |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, registered |
| flushValid | output | 1 | One-cycle flush indication |
| flushAll | output | 1 | Flush every cached translation |
| flushEntries | output | NUM_ENTRIES | Entries whose cached translations are stale |

## Verification
The hardest state to reach from the ports is a search that separates the rules that compete. One case needs a page match on an entry whose ID disagrees with the process ID. Another needs two valid overlapping entries of different page sizes. A third needs an out-of-range selector whose low bits alias a live entry. The stimulus builds each case through ordinary register writes: it switches the process ID between tag writes to create mismatched IDs, plants a 4 MiB page and a 1 KiB page at one address, then invalidates the larger page and searches again. For aliasing, it loads selector 20 and writes there. It then reads entry 4, which 20 truncates to, and expects the entry to be unchanged.

// File: rtl/tlb_mgmt_pkg.sv
package tlb_mgmt_pkg;

  localparam int WORD_W     = 32;
  localparam int VALID_BIT  = 6;
  localparam int SIZE_LSB   = 7;
  localparam int MISS_BIT   = 31;
  localparam logic [WORD_W-1:0] PAGE_NUM_MASK = 32'hFFFF_FC00;

  typedef enum logic [2:0] {
    SEL_DATA   = 3'd0,
    SEL_TAG    = 3'd1,
    SEL_PID    = 3'd2,
    SEL_ZONE   = 3'd3,
    SEL_INDEX  = 3'd4,
    SEL_SEARCH = 3'd5
  } regSel_e;

  typedef struct packed {
    logic wrData;
    logic wrTag;
    logic wrPid;
    logic wrZone;
    logic wrIndex;
    logic wrSearch;
    logic rdData;
    logic rdTag;
    logic rdPid;
    logic rdZone;
    logic rdIndex;
    logic rdZero;
  } ctrlStrobes_t;

  // Address mask for a page of 1 KiB * 4^sizeCode.
  function automatic logic [WORD_W-1:0] pageMask(input logic [2:0] sizeCode);
    logic [4:0] shiftAmt;
    shiftAmt = 5'd10 + {1'b0, sizeCode, 1'b0};
    return ~((32'd1 << shiftAmt) - 32'd1);
  endfunction

endpackage

// File: rtl/tlb_mgmt_search.sv
module tlb_mgmt_search
  import tlb_mgmt_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int TID_W       = 8,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic [WORD_W-1:0] tags [NUM_ENTRIES],
  input  logic [TID_W-1:0]  tids [NUM_ENTRIES],
  input  logic [TID_W-1:0]  curPid,
  input  logic [WORD_W-1:0] lookupAddr,
  output logic              hit,
  output logic [IDX_W-1:0]  hitIdx
);

  logic [NUM_ENTRIES-1:0] match;

  // One comparator per entry.
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    logic [WORD_W-1:0] mask;
    logic              pageOk;
    logic              tidOk;
    assign mask   = pageMask(tags[g][SIZE_LSB+2:SIZE_LSB]);
    assign pageOk = (lookupAddr & mask) == (tags[g] & mask);
    assign tidOk  = (tids[g] == '0) || (tids[g] == curPid);
    assign match[g] = tags[g][VALID_BIT] && pageOk && tidOk;
  end

  // Lowest index wins.
  always_comb begin
    hitIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hitIdx = IDX_W'(i);
    end
  end

  assign hit = |match;

endmodule

// File: rtl/tlb_mgmt_ctrl.sv
module tlb_mgmt_ctrl
  import tlb_mgmt_pkg::*;
(
  input  logic         regWrEn,
  input  logic         regRdEn,
  input  logic [2:0]   regSel,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes = '0;
    if (regWrEn) begin
      case (regSel_e'(regSel))
        SEL_DATA:   strobes.wrData   = 1'b1;
        SEL_TAG:    strobes.wrTag    = 1'b1;
        SEL_PID:    strobes.wrPid    = 1'b1;
        SEL_ZONE:   strobes.wrZone   = 1'b1;
        SEL_INDEX:  strobes.wrIndex  = 1'b1;
        SEL_SEARCH: strobes.wrSearch = 1'b1;
        default:    ;
      endcase
    end else if (regRdEn) begin
      case (regSel_e'(regSel))
        SEL_DATA:  strobes.rdData  = 1'b1;
        SEL_TAG:   strobes.rdTag   = 1'b1;
        SEL_PID:   strobes.rdPid   = 1'b1;
        SEL_ZONE:  strobes.rdZone  = 1'b1;
        SEL_INDEX: strobes.rdIndex = 1'b1;
        default:   strobes.rdZero  = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/tlb_mgmt_datapath.sv
module tlb_mgmt_datapath
  import tlb_mgmt_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int TID_W       = 8,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strobes,
  input  logic [WORD_W-1:0]      wrValue,
  output logic [WORD_W-1:0]      rdValue,
  output logic                   flushValid,
  output logic                   flushAll,
  output logic [NUM_ENTRIES-1:0] flushEntries
);

  localparam logic [8:0] ENTRY_LIM = 9'(NUM_ENTRIES);

  logic [WORD_W-1:0] tagMem  [NUM_ENTRIES];
  logic [WORD_W-1:0] dataMem [NUM_ENTRIES];
  logic [TID_W-1:0]  tidMem  [NUM_ENTRIES];
  logic [WORD_W-1:0] pidReg;
  logic [WORD_W-1:0] zoneReg;
  logic [WORD_W-1:0] indexReg;

  // Entry selection through the selector register.
  logic [7:0]        slot;
  logic              inRange;
  logic [IDX_W-1:0]  slotIdx;
  logic [WORD_W-1:0] curTag;
  logic [WORD_W-1:0] curData;
  logic [TID_W-1:0]  curTid;

  assign slot    = indexReg[7:0];
  assign inRange = {1'b0, slot} < ENTRY_LIM;
  assign slotIdx = slot[IDX_W-1:0];
  assign curTag  = inRange ? tagMem[slotIdx]  : '0;
  assign curData = inRange ? dataMem[slotIdx] : '0;
  assign curTid  = inRange ? tidMem[slotIdx]  : '0;

  // Parallel lookup for the search register.
  logic             searchHit;
  logic [IDX_W-1:0] searchIdx;
  logic [WORD_W-1:0] searchResult;

  tlb_mgmt_search #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .TID_W      (TID_W)
  ) u_search (
    .tags      (tagMem),
    .tids      (tidMem),
    .curPid    (pidReg[TID_W-1:0]),
    .lookupAddr(wrValue & PAGE_NUM_MASK),
    .hit       (searchHit),
    .hitIdx    (searchIdx)
  );

  always_comb begin
    searchResult = '0;
    searchResult[MISS_BIT] = !searchHit;
    if (searchHit) searchResult[IDX_W-1:0] = searchIdx;
  end

  // Flush sources.
  logic [NUM_ENTRIES-1:0] pidMask;
  logic [NUM_ENTRIES-1:0] tagMask;
  logic [NUM_ENTRIES-1:0] nextMask;
  logic                   nextAll;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_pidFlush
    assign pidMask[g] = tagMem[g][VALID_BIT] && (tidMem[g] != '0) &&
                        (tidMem[g] == pidReg[TID_W-1:0]);
  end

  assign tagMask = (inRange && curTag[VALID_BIT]) ?
                   ({{(NUM_ENTRIES-1){1'b0}}, 1'b1} << slotIdx) : '0;

  always_comb begin
    nextAll  = strobes.wrZone && (wrValue != zoneReg);
    nextMask = '0;
    if (strobes.wrPid && (wrValue != pidReg)) nextMask = pidMask;
    else if (strobes.wrTag)                   nextMask = tagMask;
  end

  // Read mux.
  logic              anyRead;
  logic [WORD_W-1:0] readMux;

  assign anyRead = strobes.rdData | strobes.rdTag | strobes.rdPid |
                   strobes.rdZone | strobes.rdIndex | strobes.rdZero;

  always_comb begin
    readMux = '0;
    if (strobes.rdData)  readMux = curData;
    if (strobes.rdTag)   readMux = curTag;
    if (strobes.rdPid)   readMux = pidReg;
    if (strobes.rdZone)  readMux = zoneReg;
    if (strobes.rdIndex) readMux = indexReg;
  end

  // Table storage.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        tagMem[i]  <= '0;
        dataMem[i] <= '0;
        tidMem[i]  <= '0;
      end
    end else if (inRange) begin
      if (strobes.wrTag) begin
        tagMem[slotIdx] <= wrValue;
        tidMem[slotIdx] <= pidReg[TID_W-1:0];
      end
      if (strobes.wrData) dataMem[slotIdx] <= wrValue;
    end
  end

  // Plain registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pidReg   <= '0;
      zoneReg  <= '0;
      indexReg <= '0;
    end else begin
      if (strobes.wrPid)                pidReg <= wrValue;
      else if (strobes.rdTag && inRange) pidReg <= WORD_W'(curTid);
      if (strobes.wrZone)   zoneReg  <= wrValue;
      if (strobes.wrIndex)  indexReg <= wrValue;
      if (strobes.wrSearch) indexReg <= searchResult;
    end
  end

  // Registered outputs.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValue      <= '0;
      flushValid   <= 1'b0;
      flushAll     <= 1'b0;
      flushEntries <= '0;
    end else begin
      if (anyRead) rdValue <= readMux;
      flushValid   <= nextAll || (|nextMask);
      flushAll     <= nextAll;
      flushEntries <= nextMask;
    end
  end

endmodule

// File: rtl/tlb_mgmt_regif.sv
module tlb_mgmt_regif
  import tlb_mgmt_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int TID_W       = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic                   regRdEn,
  input  logic [2:0]             regSel,
  input  logic [31:0]            regWrData,
  output logic [31:0]            regRdData,
  output logic                   flushValid,
  output logic                   flushAll,
  output logic [NUM_ENTRIES-1:0] flushEntries
);

  ctrlStrobes_t strobes;

  tlb_mgmt_ctrl u_ctrl (
    .regWrEn(regWrEn),
    .regRdEn(regRdEn),
    .regSel (regSel),
    .strobes(strobes)
  );

  tlb_mgmt_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .TID_W      (TID_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrValue     (regWrData),
    .rdValue     (regRdData),
    .flushValid  (flushValid),
    .flushAll    (flushAll),
    .flushEntries(flushEntries)
  );

endmodule

// File: rtl/tlb_mgmt_checker.sv
module tlb_mgmt_checker #(
  parameter int NUM_ENTRIES = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   regWrEn,
  input logic                   regRdEn,
  input logic [2:0]             regSel,
  input logic [31:0]            regRdData,
  input logic                   flushValid,
  input logic                   flushAll,
  input logic [NUM_ENTRIES-1:0] flushEntries
);

  // R2: read data only changes after a read-only cycle
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(!regRdEn || regWrEn) |-> $stable(regRdData));

  // R7: a whole flush only follows a zone write
  p_all_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |-> $past(regWrEn && regSel == 3'd3));

  // R7: no flush follows a cycle without a write
  p_no_flush_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(!regWrEn) |-> !flushValid);

  // R8: entry flushes only follow tag or process-ID writes
  p_entry_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|flushEntries) |-> $past(regWrEn && (regSel == 3'd1 || regSel == 3'd2)));

  // R9: a tag write flushes at most one entry
  p_tag_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(regWrEn && regSel == 3'd1) |-> $onehot0(flushEntries));

  // R8: every flush indication names something to flush
  p_flush_named_r8: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> (flushAll || $countones(flushEntries) > 0));

endmodule

bind tlb_mgmt_regif tlb_mgmt_checker #(.NUM_ENTRIES(NUM_ENTRIES)) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .regWrEn     (regWrEn),
  .regRdEn     (regRdEn),
  .regSel      (regSel),
  .regRdData   (regRdData),
  .flushValid  (flushValid),
  .flushAll    (flushAll),
  .flushEntries(flushEntries)
);

// File: tb/tb_tlb_mgmt_regif.sv
`timescale 1ns/1ps
module tb_tlb_mgmt_regif;

  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWrEn = 1'b0;
  logic         regRdEn = 1'b0;
  logic [2:0]   regSel = 3'd0;
  logic [31:0]  regWrData = '0;
  logic [31:0]  regRdData;
  logic         flushValid;
  logic         flushAll;
  logic [N-1:0] flushEntries;

  int checks = 0;
  int errors = 0;

  logic         capValid;
  logic         capAll;
  logic [N-1:0] capEntries;

  always #10 clk = ~clk;

  tlb_mgmt_regif #(.NUM_ENTRIES(N)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .flushValid(flushValid), .flushAll(flushAll), .flushEntries(flushEntries)
  );

  // Select codes: 0 data, 1 tag, 2 pid, 3 zone, 4 selector, 5 search
  localparam logic [2:0] S_DAT = 3'd0, S_TAG = 3'd1, S_PID = 3'd2,
                         S_ZON = 3'd3, S_IDX = 3'd4, S_SRC = 3'd5;

  typedef struct packed {
    logic        isWr;
    logic [2:0]  sel;
    logic [31:0] data;
    logic [31:0] expv;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1, S_IDX, 32'd2,          32'd0,          8'd3},
    '{1'b1, S_PID, 32'd5,          32'd0,          8'd4},
    '{1'b1, S_TAG, 32'h0001_0040,  32'd0,          8'd3},
    '{1'b1, S_DAT, 32'h1234_5670,  32'd0,          8'd3},
    '{1'b0, S_TAG, 32'd0,          32'h0001_0040,  8'd3},  // R3 tag readback
    '{1'b0, S_DAT, 32'd0,          32'h1234_5670,  8'd3},  // R3 data readback
    '{1'b1, S_IDX, 32'd3,          32'd0,          8'd3},
    '{1'b1, S_PID, 32'd0,          32'd0,          8'd4},
    '{1'b1, S_TAG, 32'h2000_01C0,  32'd0,          8'd5},  // 64 KiB page, ID 0
    '{1'b1, S_SRC, 32'h2000_ABCD,  32'd0,          8'd5},
    '{1'b0, S_IDX, 32'd0,          32'd3,          8'd5},  // R5 hit on 64 KiB page
    '{1'b1, S_SRC, 32'h2001_0000,  32'd0,          8'd6},
    '{1'b0, S_IDX, 32'd0,          32'h8000_0000,  8'd6},  // R6 just past page
    '{1'b1, S_SRC, 32'h0001_0123,  32'd0,          8'd6},
    '{1'b0, S_IDX, 32'd0,          32'h8000_0000,  8'd6},  // R6 ID mismatch
    '{1'b1, S_PID, 32'd5,          32'd0,          8'd5},
    '{1'b1, S_SRC, 32'h0001_03FF,  32'd0,          8'd5},
    '{1'b0, S_IDX, 32'd0,          32'd2,          8'd5}   // R5 1 KiB page, ID match
  };

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = s; regWrData = d;
    @(posedge clk); #1;
    capValid = flushValid; capAll = flushAll; capEntries = flushEntries;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic doRead(input logic [2:0] s, output logic [31:0] v);
    @(negedge clk);
    regRdEn = 1'b1; regSel = s;
    @(posedge clk); #1;
    v = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic readCheck(input string tag, input logic [2:0] s, input logic [31:0] exp);
    logic [31:0] v;
    doRead(s, v);
    checkEq(tag, v, exp);
  endtask

  task automatic flushCheck(input string tag, input logic v, input logic a, input logic [N-1:0] e);
    checkEq({tag, " flushValid"}, 32'(capValid), 32'(v));
    checkEq({tag, " flushAll"}, 32'(capAll), 32'(a));
    checkEq({tag, " flushEntries"}, 32'(capEntries), 32'(e));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state
    checkEq("R1 flushValid at reset", 32'(flushValid), 32'd0);
    readCheck("R1 data", S_DAT, 32'd0);
    readCheck("R1 tag", S_TAG, 32'd0);
    readCheck("R1 pid", S_PID, 32'd0);
    readCheck("R1 zone", S_ZON, 32'd0);
    readCheck("R1 selector", S_IDX, 32'd0);
    doWrite(S_SRC, 32'h1234_5678);
    readCheck("R1 search misses", S_IDX, 32'h8000_0000);

    // R2: unused codes
    doWrite(3'd6, 32'hFFFF_FFFF);
    readCheck("R2 reserved read", 3'd6, 32'd0);
    readCheck("R2 search read", S_SRC, 32'd0);

    // Vector table
    for (int k = 0; k < NV; k++) begin
      if (VECS[k].isWr) doWrite(VECS[k].sel, VECS[k].data);
      else readCheck($sformatf("R%0d vector %0d", VECS[k].req, k), VECS[k].sel, VECS[k].expv);
    end

    // R4: tag read loads stored ID into process-ID register
    doWrite(S_IDX, 32'd3);
    readCheck("R4 tag read", S_TAG, 32'h2000_01C0);
    readCheck("R4 pid from entry 3", S_PID, 32'd0);
    doWrite(S_IDX, 32'd2);
    readCheck("R4 tag read", S_TAG, 32'h0001_0040);
    readCheck("R4 pid from entry 2", S_PID, 32'd5);

    // R7: zone flushes
    doWrite(S_ZON, 32'h4000_0000);
    flushCheck("R7 zone change", 1'b1, 1'b1, '0);
    @(posedge clk); #1;
    checkEq("R7 pulse one cycle", 32'(flushValid), 32'd0);
    doWrite(S_ZON, 32'h4000_0000);
    flushCheck("R7 zone same", 1'b0, 1'b0, '0);
    readCheck("R2 zone readback", S_ZON, 32'h4000_0000);

    // R8: process-ID flushes use the outgoing ID
    doWrite(S_PID, 32'd9);
    flushCheck("R8 pid change", 1'b1, 1'b0, 16'h0004);
    doWrite(S_PID, 32'd9);
    flushCheck("R8 pid same", 1'b0, 1'b0, '0);

    // R9: tag write flushes
    doWrite(S_IDX, 32'd2);
    doWrite(S_TAG, 32'h0001_0040);
    flushCheck("R9 valid old tag", 1'b1, 1'b0, 16'h0004);
    doWrite(S_TAG, 32'd0);
    flushCheck("R9 invalidate", 1'b1, 1'b0, 16'h0004);
    doWrite(S_TAG, 32'd0);
    flushCheck("R9 invalid old tag", 1'b0, 1'b0, '0);

    // R10: lowest index wins (4 MiB entry 4, 1 KiB entry 5, ID 9)
    doWrite(S_IDX, 32'd4);
    doWrite(S_TAG, 32'h7000_0340);
    doWrite(S_IDX, 32'd5);
    doWrite(S_TAG, 32'h7000_0040);
    doWrite(S_SRC, 32'h7000_0000);
    readCheck("R10 overlap picks 4", S_IDX, 32'd4);
    doWrite(S_IDX, 32'd4);
    doWrite(S_TAG, 32'd0);
    doWrite(S_SRC, 32'h7000_0000);
    readCheck("R10 entry 5 after 4 invalid", S_IDX, 32'd5);

    // R11: out-of-range selector aliasing entry 4
    doWrite(S_IDX, 32'd4);
    doWrite(S_DAT, 32'h1111_0000);
    doWrite(S_IDX, 32'd20);
    doWrite(S_DAT, 32'hDEAD_BEEF);
    readCheck("R11 data read zero", S_DAT, 32'd0);
    doWrite(S_TAG, 32'h0090_0040);
    flushCheck("R11 tag write no flush", 1'b0, 1'b0, '0);
    readCheck("R11 tag read zero", S_TAG, 32'd0);
    readCheck("R11 pid unchanged", S_PID, 32'd9);
    doWrite(S_IDX, 32'd4);
    readCheck("R11 entry 4 data kept", S_DAT, 32'h1111_0000);
    readCheck("R11 entry 4 tag kept", S_TAG, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule